// File: doc/BRIEF.md
# Serial Segment-RAM Command Receiver

This block is the target end of a three-wire serial link (active-low select, serial clock, data in) that loads a display memory of 24 columns by 8 rows. The three link inputs are treated as levels already brought into the system clock domain. The block finds their edges and assembles fixed 30-bit frames. Each frame names a starting column and a direction, then carries 24 bits that cover three consecutive columns. A write frame overwrites those columns. A read frame leaves the memory alone and returns its contents on an open-drain style output, which pulls the line low or lets it float.

One address above the last column is a configuration target rather than memory. A write to it sets the number of active backplane rows and whether this unit is the timing master. A separate combinational scan port lets the row-waveform generator fetch any column at any time.

Top module: `segram_serial_rx`

## Requirements
- R1: A frame is 30 link bits, each sampled at a rising serial-clock edge: 5 address bits most significant first, one direction bit (0 = write, 1 = read), then 24 data bits. Nothing is committed until the 30th bit arrives.
- R2: A falling select starts a frame. Select may return high at any point after the first rising clock and the frame still runs to 30 bits. Rising clocks that arrive when no frame is open are ignored.
- R3: A falling select before 30 bits have been taken drops the partial frame without any effect and starts counting a new one.
- R4: In a write to start column A (0 to 23), data bit j (0 = first sent) lands in column A + j/8 at row j mod 8. The scan port shows row r of a column at bit r.
- R5: The three columns of a burst are A, A+1 and A+2 modulo 24, so starts of 22 and 23 wrap into column 0.
- R6: A read frame never changes the memory. After the falling clock edge of link clocks 7 through 30, burst bit (clock number − 7) is presented: the output pulls low when that stored bit is 0 and is released when it is 1. The bit is held until the next such edge or a new frame.
- R7: The output is released out of reset, from every frame start until a read presents a bit, and throughout write frames.
- R8: A write to address 24 is a mode frame and leaves the memory unchanged. Its first three data bits form a count field (first bit most significant), and the backplane count becomes field + 1, so 000 gives 1 and 111 gives 8. Its fourth data bit sets master (1) or slave (0). The other 20 bits are ignored.
- R9: The mode cannot be read back: a read of address 24 keeps the output released. Addresses 25 to 31 neither write nor drive the output. Neither changes the mode.
- R10: After reset the memory is all zero, the backplane count is 8, master is set and the output is released.
- R11: The scan port returns the selected column combinationally, and returns zero for columns 24 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Link select, active low, synchronous level |
| sclk | input | 1 | Link serial clock, synchronous level |
| sdi | input | 1 | Link serial data in |
| sdo_pull_low | output | 1 | 1 pulls the return line low, 0 releases it |
| scan_col | input | 5 | Column selected on the scan port |
| scan_rows | output | 8 | Rows of the selected column, row r at bit r |
| bp_count | output | 4 | Active backplane row count, 1 to 8 |
| is_master | output | 1 | 1 when configured as timing master |

## Verification
The bench builds the block with its default geometry: 24 columns, 8 rows, three-column bursts and a 5-bit address. With this geometry, starts of 22 and 23 exercise the wrap into column 0. The mode address sits directly past the last column, and the spare codes 25 to 31 probe the out-of-range handling. A protocol-level model follows each link edge and is compared with the output pin, the mode outputs and a rotating scan column on every clock. Directed frames add aborted, early-deselected and stray-clock cases.

// File: rtl/segrx_pkg.sv
package segrx_pkg;

    localparam int unsigned SEG_COLS      = 24;
    localparam int unsigned SEG_ROWS      = 8;
    localparam int unsigned SEG_BURST     = 3;
    localparam int unsigned SEG_ADDR_W    = 5;
    localparam int unsigned SEG_MODE_ADDR = 24;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
    } link_ev_t;

endpackage

// File: rtl/segrx_edge.sv
module segrx_edge
    import segrx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_n,
    input  logic     sclk,
    output link_ev_t ev
);

    typedef struct packed {
        logic sclk;
        logic cs_n;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d.sclk = sclk;
        st_d.cs_n = cs_n;
        ev.rise   = sclk & ~st_q.sclk;
        ev.fall   = ~sclk & st_q.sclk;
        ev.start  = ~cs_n & st_q.cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sclk <= 1'b0;
            st_q.cs_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/segrx_frame.sv
module segrx_frame
    import segrx_pkg::*;
#(
    parameter int unsigned ADDR_W     = SEG_ADDR_W,
    parameter int unsigned DATA_W     = SEG_BURST * SEG_ROWS,
    parameter int unsigned FRAME_BITS = ADDR_W + 1 + DATA_W,
    parameter int unsigned CNT_W      = $clog2(FRAME_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  link_ev_t          ev,
    input  logic              sdi,
    output logic [CNT_W-1:0]  cnt,
    output logic [ADDR_W-1:0] addr,
    output logic              rw,
    output logic [DATA_W-1:0] data_full,
    output logic              commit
);

    localparam logic [CNT_W-1:0] RW_POS   = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              rw;
        logic [DATA_W-1:0] data;
    } frame_st_t;

    frame_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        commit    = 1'b0;
        data_full = {st_q.data[DATA_W-2:0], sdi};
        if (ev.start) begin
            // a new select edge always wins and throws away any partial frame
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (ev.rise && st_q.active) begin
            if (st_q.cnt < RW_POS) begin
                st_d.addr = {st_q.addr[ADDR_W-2:0], sdi};
            end else if (st_q.cnt == RW_POS) begin
                st_d.rw = sdi;
            end else begin
                st_d.data = data_full;
            end
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_POS) begin
                st_d.active = 1'b0;
                commit      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign addr = st_q.addr;
    assign rw   = st_q.rw;

endmodule

// File: rtl/segrx_colmap.sv
module segrx_colmap
    import segrx_pkg::*;
#(
    parameter int unsigned COLS   = SEG_COLS,
    parameter int unsigned ADDR_W = SEG_ADDR_W,
    parameter int unsigned BURST  = SEG_BURST
) (
    input  logic [ADDR_W-1:0]            start,
    output logic [BURST-1:0][ADDR_W-1:0] cols
);

    localparam int unsigned SUM_W = ADDR_W + 1;

    for (genvar k = 0; k < BURST; k++) begin : g_col
        logic [SUM_W-1:0] sum;
        logic [SUM_W-1:0] folded;
        assign sum    = {1'b0, start} + SUM_W'(k);
        assign folded = (sum >= SUM_W'(COLS)) ? sum - SUM_W'(COLS) : sum;
        assign cols[k] = folded[ADDR_W-1:0];
    end

endmodule

// File: rtl/segram_serial_rx.sv
module segram_serial_rx
    import segrx_pkg::*;
#(
    parameter int unsigned COLS      = SEG_COLS,
    parameter int unsigned ROWS      = SEG_ROWS,
    parameter int unsigned BURST     = SEG_BURST,
    parameter int unsigned ADDR_W    = SEG_ADDR_W,
    parameter int unsigned MODE_ADDR = SEG_MODE_ADDR
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     sclk,
    input  logic                     sdi,
    output logic                     sdo_pull_low,
    input  logic [ADDR_W-1:0]        scan_col,
    output logic [ROWS-1:0]          scan_rows,
    output logic [$clog2(ROWS+1)-1:0] bp_count,
    output logic                     is_master
);

    localparam int unsigned DATA_W     = BURST * ROWS;
    localparam int unsigned FRAME_BITS = ADDR_W + 1 + DATA_W;
    localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int unsigned MODE_W     = $clog2(ROWS);
    localparam int unsigned BP_W       = $clog2(ROWS + 1);
    localparam int unsigned FIRST_OUT  = ADDR_W + 2;

    localparam logic [ADDR_W-1:0] LAST_COL  = ADDR_W'(COLS - 1);
    localparam logic [ADDR_W-1:0] MODE_CODE = ADDR_W'(MODE_ADDR);
    localparam logic [CNT_W-1:0]  OUT_POS   = CNT_W'(FIRST_OUT);

    typedef struct packed {
        logic [COLS-1:0][ROWS-1:0] mem;
        logic [MODE_W-1:0]         bp_field;
        logic                      master;
        logic                      sdo_low;
    } core_st_t;

    core_st_t st_d, st_q;

    link_ev_t                  ev;
    logic [CNT_W-1:0]          frm_cnt;
    logic [ADDR_W-1:0]         frm_addr;
    logic                      frm_rw;
    logic [DATA_W-1:0]         frm_data;
    logic                      frm_commit;
    logic [BURST-1:0][ADDR_W-1:0] col_sel;
    logic [CNT_W-1:0]          rd_idx;
    logic [CNT_W-1:0]          rd_off;
    logic [CNT_W-1:0]          rd_row;
    logic                      addr_in_mem;

    segrx_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sclk  (sclk),
        .ev    (ev)
    );

    segrx_frame #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .FRAME_BITS (FRAME_BITS),
        .CNT_W      (CNT_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .sdi       (sdi),
        .cnt       (frm_cnt),
        .addr      (frm_addr),
        .rw        (frm_rw),
        .data_full (frm_data),
        .commit    (frm_commit)
    );

    segrx_colmap #(
        .COLS   (COLS),
        .ADDR_W (ADDR_W),
        .BURST  (BURST)
    ) u_colmap (
        .start (frm_addr),
        .cols  (col_sel)
    );

    assign addr_in_mem = (frm_addr <= LAST_COL);
    assign rd_idx      = frm_cnt - OUT_POS;
    assign rd_off      = rd_idx / CNT_W'(ROWS);
    assign rd_row      = rd_idx % CNT_W'(ROWS);

    always_comb begin
        st_d = st_q;
        // commit point: only the 30th rising edge of a write frame touches state
        if (frm_commit && !frm_rw) begin
            if (addr_in_mem) begin
                for (int k = 0; k < int'(BURST); k++) begin
                    for (int r = 0; r < int'(ROWS); r++) begin
                        st_d.mem[col_sel[k]][r] = frm_data[DATA_W-1-(k*ROWS+r)];
                    end
                end
            end else if (frm_addr == MODE_CODE) begin
                st_d.bp_field = frm_data[DATA_W-1 -: MODE_W];
                st_d.master   = frm_data[DATA_W-1-MODE_W];
            end
        end
        // return line: released on every frame start, updated on falling clocks of a read
        if (ev.start) begin
            st_d.sdo_low = 1'b0;
        end else if (ev.fall && frm_rw && addr_in_mem && (frm_cnt >= OUT_POS)) begin
            st_d.sdo_low = ~st_q.mem[col_sel[rd_off]][rd_row];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mem      <= '0;
            st_q.bp_field <= MODE_W'(ROWS - 1);
            st_q.master   <= 1'b1;
            st_q.sdo_low  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo_pull_low = st_q.sdo_low;
    assign scan_rows    = (scan_col <= LAST_COL) ? st_q.mem[scan_col] : '0;
    assign bp_count     = BP_W'(st_q.bp_field) + BP_W'(1);
    assign is_master    = st_q.master;

endmodule

// File: rtl/segrx_checker.sv
module segrx_checker #(
    parameter int unsigned COLS      = 24,
    parameter int unsigned ROWS      = 8,
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned MODE_ADDR = 24
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cs_fall,
    input logic                      sclk_fall,
    input logic                      commit,
    input logic                      frame_rw,
    input logic [ADDR_W-1:0]         frame_addr,
    input logic [COLS*ROWS-1:0]      mem_bits,
    input logic                      sdo_pull_low,
    input logic [$clog2(ROWS+1)-1:0] bp_count,
    input logic                      is_master
);

    localparam logic [ADDR_W-1:0] MODE_CODE = ADDR_W'(MODE_ADDR);
    localparam logic [ADDR_W-1:0] LAST_COL  = ADDR_W'(COLS - 1);

    assert_mem_waits_commit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(mem_bits));

    assert_read_keeps_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && frame_rw) |=> $stable(mem_bits));

    assert_sdo_edges_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs_fall || sclk_fall) |=> $stable(sdo_pull_low));

    assert_sdo_read_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_pull_low |-> frame_rw);

    assert_sdo_release_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> !sdo_pull_low);

    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && !frame_rw && frame_addr == MODE_CODE) |=> $stable({bp_count, is_master}));

    assert_high_addr_keeps_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && frame_addr > LAST_COL) |=> $stable(mem_bits));

endmodule

bind segram_serial_rx segrx_checker #(
    .COLS      (COLS),
    .ROWS      (ROWS),
    .ADDR_W    (ADDR_W),
    .MODE_ADDR (MODE_ADDR)
) u_segrx_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_fall      (ev.start),
    .sclk_fall    (ev.fall),
    .commit       (frm_commit),
    .frame_rw     (frm_rw),
    .frame_addr   (frm_addr),
    .mem_bits     (st_q.mem),
    .sdo_pull_low (sdo_pull_low),
    .bp_count     (bp_count),
    .is_master    (is_master)
);

// File: tb/segram_serial_rx_bench.sv
module segram_serial_rx_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic [4:0] scan_col = '0;
    logic       sdo_pull_low;
    logic [7:0] scan_rows;
    logic [3:0] bp_count;
    logic       is_master;

    always #(CLK_PERIOD/2) clk = ~clk;

    segram_serial_rx u_segram_serial_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .sclk         (sclk),
        .sdi          (sdi),
        .sdo_pull_low (sdo_pull_low),
        .scan_col     (scan_col),
        .scan_rows    (scan_rows),
        .bp_count     (bp_count),
        .is_master    (is_master)
    );

    int checks = 0;
    int errors = 0;
    bit cmp_en = 0;
    bit finished = 0;

    // behavioural protocol model
    logic [7:0] ref_mem [24];
    int ref_bp = 8;
    int ref_master = 1;
    int exp_low = 0;
    int m_active = 0;
    int m_cnt = 0;
    int m_addr = 0;
    int m_rw = 0;
    int m_bits [24];

    initial for (int c = 0; c < 24; c++) ref_mem[c] = 8'h00;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int rev8(int v);
        int o = 0;
        for (int i = 0; i < 8; i++) if ((v >> i) & 1) o |= 1 << (7 - i);
        return o;
    endfunction

    task automatic model_start();
        m_active = 1;
        m_cnt    = 0;
        exp_low  = 0;
    endtask

    task automatic model_rise(int b);
        if (m_active == 0) return;
        if (m_cnt < 5) m_addr = m_addr * 2 + b - ((m_addr >= 16) ? 32 : 0);
        else if (m_cnt == 5) m_rw = b;
        else m_bits[m_cnt-6] = b;
        m_cnt++;
        if (m_cnt == 30) begin
            m_active = 0;
            if (m_rw == 0 && m_addr < 24) begin
                for (int j = 0; j < 24; j++)
                    ref_mem[(m_addr + j/8) % 24][j%8] = m_bits[j][0];
            end else if (m_rw == 0 && m_addr == 24) begin
                ref_bp     = m_bits[0]*4 + m_bits[1]*2 + m_bits[2] + 1;
                ref_master = m_bits[3];
            end
        end
    endtask

    task automatic model_fall();
        if (m_rw == 1 && m_cnt >= 7 && m_addr < 24) begin
            int j = m_cnt - 7;
            exp_low = ref_mem[(m_addr + j/8) % 24][j%8] ? 0 : 1;
        end
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic rotate_scan();
        scan_col = scan_col + 5'd1;
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (cmp_en) begin
            check("R6 R7 sdo_pull_low", int'(sdo_pull_low), exp_low);
            check("R8 bp_count", int'(bp_count), ref_bp);
            check("R8 is_master", int'(is_master), ref_master);
            check("R11 scan_rows", int'(scan_rows),
                  (scan_col < 24) ? int'(ref_mem[scan_col]) : 0);
        end
    end

    task automatic send_bit(int b);
        @(negedge clk);
        sdi  = b[0];
        sclk = 1'b1;
        after_edge();
        model_rise(b);
        rotate_scan();
        @(negedge clk);
        @(negedge clk);
        sclk = 1'b0;
        after_edge();
        model_fall();
        rotate_scan();
    endtask

    task automatic cs_start();
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
        after_edge();
        model_start();
    endtask

    task automatic frame(int a, int rw, logic [23:0] d, int nbits = 30, int hi_after = 0);
        cs_start();
        for (int i = 0; i < nbits; i++) begin
            int b;
            if (i < 5) b = (a >> (4 - i)) & 1;
            else if (i == 5) b = rw;
            else b = int'(d[29-i]);
            send_bit(b);
            if (i + 1 == hi_after) begin
                @(negedge clk);
                cs_n = 1'b1;
            end
        end
    endtask

    task automatic col_check(string tag, int col, int exp);
        after_edge();
        scan_col = col[4:0];
        @(negedge clk);
        check(tag, int'(scan_rows), exp);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 sdo released", int'(sdo_pull_low), 0);
        check("R10 bp_count", int'(bp_count), 8);
        check("R10 is_master", int'(is_master), 1);
        cmp_en = 1;
        col_check("R10 column 0 clear", 0, 0);
        col_check("R10 column 23 clear", 23, 0);

        // R1 R4 bit placement
        frame(3, 0, {8'h80, 8'h01, 8'hF0});
        col_check("R1 R4 column 3", 3, rev8(8'h80));
        col_check("R4 column 4", 4, 8'h80);
        col_check("R4 column 5", 5, 8'h0F);

        // R5 wrap
        frame(23, 0, {8'h11, 8'h22, 8'h44});
        col_check("R5 column 23", 23, 8'h88);
        col_check("R5 column 0", 0, rev8(8'h22));
        col_check("R5 column 1", 1, rev8(8'h44));
        frame(22, 0, {8'h03, 8'h0C, 8'h30});
        col_check("R5 column 22", 22, 8'hC0);
        col_check("R5 column 23 rewrite", 23, 8'h30);
        col_check("R5 column 0 rewrite", 0, 8'h0C);

        // R6 read: last presented bit is column 5 row 7 = 0 -> pulled low
        frame(3, 1, 24'h000000);
        check("R6 last read bit pulls low", int'(sdo_pull_low), 1);
        col_check("R6 memory kept after read", 3, 8'h01);

        // R7 write frame releases line
        frame(9, 0, 24'h000000);
        check("R7 released after write", int'(sdo_pull_low), 0);
        col_check("R7 column 9 zero", 9, 0);

        // R8 mode frames
        frame(24, 0, {3'b010, 1'b0, 20'hFFFFF});
        @(negedge clk);
        check("R8 count field 010", int'(bp_count), 3);
        check("R8 slave", int'(is_master), 0);
        col_check("R8 memory unchanged", 0, 8'h0C);
        frame(24, 0, {3'b000, 1'b1, 20'h00000});
        @(negedge clk);
        check("R8 count field 000", int'(bp_count), 1);
        check("R8 master", int'(is_master), 1);
        frame(24, 0, {3'b110, 1'b1, 20'hAAAAA});
        @(negedge clk);
        check("R8 count field 110", int'(bp_count), 7);

        // R9 mode unreadable, spare addresses inert
        frame(24, 1, 24'h000000);
        check("R9 mode read released", int'(sdo_pull_low), 0);
        check("R9 mode kept", int'(bp_count), 7);
        frame(27, 0, 24'hFFFFFF);
        col_check("R9 spare write column 3", 3, 8'h01);
        col_check("R9 spare write column 4", 4, 8'h80);
        frame(27, 1, 24'h000000);
        check("R9 spare read released", int'(sdo_pull_low), 0);

        // R3 abort, R1 no commit before 30th bit
        frame(12, 0, 24'hFFFFFF, 20);
        frame(15, 0, {8'h01, 8'h02, 8'h04});
        col_check("R3 aborted column 12", 12, 0);
        col_check("R3 column 15", 15, 8'h80);
        col_check("R3 column 17", 17, 8'h20);
        frame(18, 0, 24'hFFFFFF, 29);
        frame(20, 0, 24'h000000);
        col_check("R1 29-bit frame not committed", 18, 0);

        // R2 early deselect and stray clocks
        frame(6, 0, {8'hFF, 8'h00, 8'h81}, 30, 1);
        col_check("R2 column 6", 6, 8'hFF);
        col_check("R2 column 8", 8, 8'h81);
        @(negedge clk);
        cs_n = 1'b1;
        for (int i = 0; i < 30; i++) send_bit(0);
        col_check("R2 stray clocks ignored", 6, 8'hFF);

        // R11 out-of-range scan
        col_check("R11 column 28", 28, 0);
        col_check("R11 column 31", 31, 0);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule